// File: doc/BRIEF.md
# Split Row/Column Command Bus Conflict Checker

This block observes a decoded stream of memory commands, at most one per clock, and reports when a command is placed on a command bus that an earlier command still holds. The memory has two independent command buses. The row bus carries activations, precharges and refreshes. The column bus carries reads and writes. Power-down and self-refresh entry and exit commands drive both buses at once, so both must be free for them.

An activation keeps the row bus for two cycles. Every other row-bus command keeps it for one. A column command keeps the column bus for one cycle. Each hold length is a parameter. Every result is registered: the conflict pulse, the class tag of the offending command and the unknown-opcode flag all appear in the cycle after the command. The block sits beside a memory controller's command path as a protocol monitor and has no other interface.

Top module: `cmd_bus_guard`

## Requirements
- R1: A synchronous active-high `rst` clears both bus holds, and in the cycle after a reset edge `conflict_o`, `conflict_kind` and `bad_op` are all 0.
- R2: The opcode codes are as follows. Row-bus only: 0 activate, 1 precharge one bank, 2 precharge all, 3 refresh one bank, 4 refresh all. Column-bus only: 5 read, 6 read with auto-precharge, 7 write, 8 write with auto-precharge. Both buses: 9 active power-down in, 10 active power-down out, 11 precharged power-down in, 12 precharged power-down out, 13 self-refresh in, 14 self-refresh out.
- R3: A valid command that uses the row bus, issued in the cycle right after a valid activate, is flagged. `conflict_o` is 1 in the following cycle.
- R4: A row-bus command other than activate holds the row bus for one cycle only, so a row command in the next cycle is not flagged.
- R5: A column command holds the column bus for one cycle only, so back-to-back column commands are not flagged.
- R6: The two buses are independent. A column-only command in the cycle after an activate is not flagged.
- R7: A both-bus command is checked against both holds and is flagged if either bus is still held, for example right after an activate.
- R8: When a conflict is flagged, `conflict_kind` gives the class of the offending command: 2'b01 row only, 2'b10 column only, 2'b11 both. When no conflict is flagged it is 2'b00.
- R9: Opcode 15 with `cmd_valid` high sets `bad_op` in the next cycle. It never sets `conflict_o` and claims no bus.
- R10: A flagged command still drives its bus and reloads that bus's hold. An activate flagged right after an activate makes a row command in the next cycle conflict as well.
- R11: With `cmd_valid` low the opcode is ignored. It claims no bus and causes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 4 | Command opcode (see R2) |
| conflict_o | output | 1 | Bus conflict seen on the previous cycle's command |
| conflict_kind | output | 2 | Class of the offending command (see R8) |
| bad_op | output | 1 | Previous cycle's valid command had an unknown opcode |

## Verification
Two things can happen in the same cycle. A command can be flagged and, in that same cycle, reload the hold of the bus it collided on. A both-bus command can also arrive while an activation still holds the row bus. The bench provokes the first with back-to-back activates followed by a row command, and the second by placing each power-down or self-refresh code right after an activate. A scoreboard model, written from the requirements, predicts the flag and the tag for every cycle. Alternating activates with column commands shows that the column bus stays free while the row bus is held.

// File: rtl/cmd_bus_pkg.sv
package cmd_bus_pkg;

  typedef enum logic [3:0] {
    OP_ACT         = 4'd0,
    OP_PRE_ONE     = 4'd1,
    OP_PRE_ALL     = 4'd2,
    OP_REF_ONE     = 4'd3,
    OP_REF_ALL     = 4'd4,
    OP_RD          = 4'd5,
    OP_RD_AP       = 4'd6,
    OP_WR          = 4'd7,
    OP_WR_AP       = 4'd8,
    OP_PDN_ACT_IN  = 4'd9,
    OP_PDN_ACT_OUT = 4'd10,
    OP_PDN_PRE_IN  = 4'd11,
    OP_PDN_PRE_OUT = 4'd12,
    OP_SR_IN       = 4'd13,
    OP_SR_OUT      = 4'd14,
    OP_UNUSED      = 4'd15
  } cmd_op_e;

  // Class tag values reported with a conflict
  localparam logic [1:0] KIND_NONE = 2'b00;
  localparam logic [1:0] KIND_ROW  = 2'b01;
  localparam logic [1:0] KIND_COL  = 2'b10;
  localparam logic [1:0] KIND_BOTH = 2'b11;

  function automatic logic op_known(input logic [3:0] op);
    return op != OP_UNUSED;
  endfunction

  // Row bus: codes 0..4 and the shared codes 9..14
  function automatic logic op_uses_row(input logic [3:0] op);
    return (op <= OP_REF_ALL) || ((op >= OP_PDN_ACT_IN) && (op <= OP_SR_OUT));
  endfunction

  // Column bus: codes 5..8 and the shared codes 9..14
  function automatic logic op_uses_col(input logic [3:0] op);
    return (op >= OP_RD) && (op <= OP_SR_OUT);
  endfunction

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
  import cmd_bus_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] op,
  output logic       is_known,
  output logic       is_unknown,
  output logic       on_row,
  output logic       on_col,
  output logic       is_act
);
  always_comb begin
    is_known   = valid && op_known(op);
    is_unknown = valid && !op_known(op);
    on_row     = is_known && op_uses_row(op);
    on_col     = is_known && op_uses_col(op);
    is_act     = is_known && (op == OP_ACT);
  end
endmodule

// File: rtl/bus_hold.sv
module bus_hold #(
  parameter int HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              claim,
  input  logic [HOLD_W-1:0] hold_len,
  output logic              busy
);
  logic [HOLD_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)
      remain_q <= '0;
    else if (claim)
      remain_q <= hold_len - HOLD_W'(1);
    else if (remain_q != '0)
      remain_q <= remain_q - HOLD_W'(1);
  end

  assign busy = (remain_q != '0);
endmodule

// File: rtl/cmd_bus_guard.sv
module cmd_bus_guard
  import cmd_bus_pkg::*;
#(
  parameter int ROW_ACT_HOLD = 2,
  parameter int ROW_HOLD     = 1,
  parameter int COL_HOLD     = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_op,
  output logic       conflict_o,
  output logic [1:0] conflict_kind,
  output logic       bad_op
);
  localparam int MAX_HOLD = max_of3(ROW_ACT_HOLD, ROW_HOLD, COL_HOLD);
  localparam int HOLD_W   = (MAX_HOLD < 2) ? 1 : $clog2(MAX_HOLD + 1);
  localparam int NBUS     = 2;   // index 0 row bus, 1 column bus

  logic is_known, is_unknown, on_row, on_col, is_act;
  logic row_busy, col_busy, row_hit, col_hit, any_hit;
  logic [NBUS-1:0]   bus_claim, bus_busy;
  logic [HOLD_W-1:0] bus_len [NBUS];

  cmd_classify u_cls (
    .valid      (cmd_valid),
    .op         (cmd_op),
    .is_known   (is_known),
    .is_unknown (is_unknown),
    .on_row     (on_row),
    .on_col     (on_col),
    .is_act     (is_act)
  );

  assign bus_claim  = {on_col, on_row};
  assign bus_len[0] = is_act ? HOLD_W'(ROW_ACT_HOLD) : HOLD_W'(ROW_HOLD);
  assign bus_len[1] = HOLD_W'(COL_HOLD);

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    bus_hold #(.HOLD_W(HOLD_W)) u_hold (
      .clk      (clk),
      .rst      (rst),
      .claim    (bus_claim[b]),
      .hold_len (bus_len[b]),
      .busy     (bus_busy[b])
    );
  end

  assign row_busy = bus_busy[0];
  assign col_busy = bus_busy[1];
  assign row_hit  = on_row && row_busy;
  assign col_hit  = on_col && col_busy;
  assign any_hit  = row_hit || col_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      conflict_o    <= 1'b0;
      conflict_kind <= KIND_NONE;
      bad_op        <= 1'b0;
    end else begin
      conflict_o    <= any_hit;
      conflict_kind <= any_hit ? {on_col, on_row} : KIND_NONE;
      bad_op        <= is_unknown;
    end
  end
endmodule

// File: rtl/cmd_bus_guard_sva.sv
module cmd_bus_guard_sva
  import cmd_bus_pkg::*;
#(
  parameter int COL_HOLD = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic       conflict_o,
  input logic [1:0] conflict_kind,
  input logic       bad_op,
  input logic       row_busy,
  input logic       col_busy
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!conflict_o && !bad_op && conflict_kind == KIND_NONE));

  assert_act_blocks_row_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cmd_valid && cmd_op == OP_ACT) && cmd_valid && op_uses_row(cmd_op))
    |=> conflict_o);

  assert_col_free_after_act_R6: assert property (@(posedge clk) disable iff (rst)
    ((COL_HOLD <= 2) && $past(!rst) && $past(cmd_valid && cmd_op == OP_ACT) &&
     cmd_valid && op_uses_col(cmd_op) && !op_uses_row(cmd_op))
    |=> !conflict_o);

  assert_free_buses_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !row_busy && !col_busy) |=> !conflict_o);

  assert_kind_set_R8: assert property (@(posedge clk) disable iff (rst)
    conflict_o |-> (conflict_kind != KIND_NONE));

  assert_kind_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !conflict_o |-> (conflict_kind == KIND_NONE));

  assert_unknown_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_UNUSED) |=> (bad_op && !conflict_o));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({conflict_o, bad_op}));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> (!conflict_o && !bad_op));
endmodule

bind cmd_bus_guard cmd_bus_guard_sva #(.COL_HOLD(COL_HOLD)) u_sva (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .conflict_o    (conflict_o),
  .conflict_kind (conflict_kind),
  .bad_op        (bad_op),
  .row_busy      (row_busy),
  .col_busy      (col_busy)
);

// File: tb/test_cmd_bus_guard.sv
module test_cmd_bus_guard;
  localparam int CLK_PERIOD = 10;
  localparam int T_ACT = 2;
  localparam int T_ROW = 1;
  localparam int T_COL = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = 4'd0;
  logic       conflict_o;
  logic [1:0] conflict_kind;
  logic       bad_op;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;
  int m_row = 0;
  int m_col = 0;

  logic [3:0] exp_q[$];
  string      req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_bus_guard i_cmd_bus_guard (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .conflict_o(conflict_o), .conflict_kind(conflict_kind), .bad_op(bad_op)
  );

  // Driver: applies one cycle and pushes the predicted {conflict, kind, bad}
  task automatic apply(input bit r, input bit v, input int op, input string req);
    bit rowu, colu, hit, bad;
    logic [1:0] kind;
    @(negedge clk);
    rst = r; cmd_valid = v; cmd_op = 4'(op);
    rowu = 0; colu = 0; hit = 0; bad = 0; kind = 2'b00;
    if (r) begin
      m_row = 0; m_col = 0;
    end else begin
      if (v && op == 15) bad = 1;
      else if (v) begin
        if (op inside {[0:4]})  rowu = 1;
        if (op inside {[5:8]})  colu = 1;
        if (op inside {[9:14]}) begin rowu = 1; colu = 1; end
      end
      hit = (rowu && m_row > 0) || (colu && m_col > 0);
      if (hit) kind = {colu, rowu};
      if (rowu) m_row = (op == 0) ? T_ACT - 1 : T_ROW - 1;
      else if (m_row > 0) m_row--;
      if (colu) m_col = T_COL - 1;
      else if (m_col > 0) m_col--;
    end
    exp_q.push_back({hit, kind, bad});
    req_q.push_back(req);
  endtask

  // Monitor: compares just after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        logic [3:0] e;
        string rq;
        e = exp_q.pop_front();
        rq = req_q.pop_front();
        n_checks++;
        if ({conflict_o, conflict_kind, bad_op} !== e) begin
          n_fails++;
          $display("FAIL %s: got {conflict,kind,bad}=%b expected %b", rq,
                   {conflict_o, conflict_kind, bad_op}, e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    apply(1, 0, 0, "R1"); apply(1, 1, 0, "R1"); apply(1, 0, 0, "R1");
    apply(0, 0, 0, "R1");
    // R3 activate then each row-only code
    for (int k = 0; k <= 4; k++) begin
      apply(0, 1, 0, "R3"); apply(0, 1, k, "R3_R8"); apply(0, 0, 0, "R3");
    end
    // R4 non-activate row commands back to back
    for (int k = 1; k <= 4; k++) apply(0, 1, k, "R4");
    apply(0, 1, 0, "R4"); apply(0, 0, 0, "R4"); apply(0, 1, 2, "R4");
    // R5 column commands back to back
    for (int k = 5; k <= 8; k++) apply(0, 1, k, "R5");
    apply(0, 1, 5, "R5"); apply(0, 1, 7, "R5");
    // R6 alternating activates and column commands
    for (int k = 5; k <= 8; k++) begin
      apply(0, 1, 0, "R6"); apply(0, 1, k, "R6"); apply(0, 0, 0, "R6");
    end
    // R7 both-bus codes right after an activate, and after free buses
    for (int k = 9; k <= 14; k++) begin
      apply(0, 1, 0, "R7"); apply(0, 1, k, "R7_R8"); apply(0, 1, k, "R7");
      apply(0, 0, 0, "R7");
    end
    apply(0, 1, 5, "R7"); apply(0, 1, 13, "R7");
    // R10 flagged activate reloads the row hold
    apply(0, 1, 0, "R10"); apply(0, 1, 0, "R10"); apply(0, 1, 1, "R10");
    apply(0, 0, 0, "R10");
    apply(0, 1, 0, "R10"); apply(0, 1, 1, "R10"); apply(0, 1, 1, "R10");
    // R9 unknown code claims no bus
    apply(0, 1, 0, "R9"); apply(0, 1, 15, "R9"); apply(0, 1, 1, "R9");
    apply(0, 1, 15, "R9"); apply(0, 1, 15, "R9");
    // R11 invalid strobe with activate code ignored
    apply(0, 0, 0, "R11"); apply(0, 1, 1, "R11"); apply(0, 0, 15, "R11");
    apply(0, 0, 9, "R11");
    // R1 reset in the middle of an activate hold
    apply(0, 1, 0, "R1"); apply(1, 0, 0, "R1"); apply(0, 1, 1, "R1");
    apply(0, 1, 0, "R2"); apply(0, 1, 6, "R2"); apply(0, 1, 12, "R2");
    apply(0, 0, 0, "R2");
    @(negedge clk);
    cmd_valid = 0;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule